// File: doc/BRIEF.md
# Dual-Channel Legacy I/O Port Register Block

This block sits on a legacy PC I/O bus and gives the host two output bytes and two input bytes. It compares the low eleven address bits against one of four base addresses, chosen by a two-bit jumper input. A matching access is decoded into eight one-hot local selects. A host write at offset 0 or 1 stores the bus byte in output register 1 or 2. A host read at offset 0 or 1 places input register 1 or 2 on the bus.

Offsets 4 and 5 fill the input registers. In internal capture mode, any host access to one of these offsets, read or write, latches the external byte of that channel into its input register. The external circuit then needs no strobe logic of its own. Each channel can also be switched to external capture mode. In that mode the external side loads the register with an active-low strobe of its own, and host accesses at offsets 4 and 5 have no effect.

The bus strobes are active low. A register loads on the deasserting (rising) edge of the strobe that qualifies it. The block detects that edge by sampling the strobe on the block clock. The clock must be fast enough to sample a 62.5 ns bus cycle at least twice. All bus inputs are taken to be synchronous to that clock.

Top module: `ioport_regs`

## Requirements
- R1: While reset is asserted, both output registers and both input registers are zero, so `out_data` reads 0 and host reads at offsets 0 and 1 return 0.
- R2: An access is decoded only when address bits 10..3 equal bits 10..3 of the base 0x300 + 0x10 × `base_sel`. Address bits above bit 10 are ignored. An access at any other address has no effect.
- R3: While `io_aen` is 1, no access is decoded. Writes do not load, captures do not happen, and `io_rdata_oe` stays 0.
- R4: When `io_wr_n` rises after a low phase at offset 0 (or 1), output register 1 (or 2) loads the byte that was on `io_wdata` during that low phase. Output register 1 is `out_data[7:0]` and output register 2 is `out_data[15:8]`. The new value appears on the clock edge after the rise is sampled.
- R5: While `io_rd_n` is low at offset 0 (or 1), `io_rdata_oe` is 1 and `io_rdata` equals input register 1 (or 2).
- R6: In internal capture mode (`cap_ext[ch]` = 0), a read or a write at offset 4 (for channel 0) or offset 5 (for channel 1) loads `ext_data` of that channel into its input register when the strobe rises. A read at offset 4 or 5 never drives the bus.
- R7: In external capture mode (`cap_ext[ch]` = 1), a rising edge of `ext_stb_n[ch]` loads `ext_data` of that channel into its input register, and host accesses at offset 4 or 5 have no effect. In internal mode, `ext_stb_n` is ignored.
- R8: Writes at offsets 2, 3, 6 and 7 change no register. Reads at those offsets leave `io_rdata_oe` at 0.
- R9: Whenever `io_rdata_oe` is 0, `io_rdata` is 0.
- R10: `out_data` changes only on the clock edge that follows a sampled rising edge of `io_wr_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples all bus signals |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | Host I/O address |
| io_aen | input | 1 | High during DMA cycles; blocks all decoding |
| io_rd_n | input | 1 | Active-low host I/O read strobe |
| io_wr_n | input | 1 | Active-low host I/O write strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Read data toward the host; 0 when not driving |
| io_rdata_oe | output | 1 | Bus drive enable for `io_rdata` |
| base_sel | input | 2 | Jumper selection of the base address |
| cap_ext | input | 2 | Per-channel capture mode: 1 = external strobe |
| ext_stb_n | input | 2 | Per-channel active-low external capture strobe |
| ext_data | input | 16 | External bytes; channel 0 in bits 7..0 |
| out_data | output | 16 | Output registers; register 1 in bits 7..0 |

## Verification
The assertions check four properties on every cycle. The bus is driven only during a host read at offset 0 or 1 with `io_aen` low. The read data is quiet whenever the bus is not driven. The output registers change only right after a write strobe rises. Reset holds the outputs at zero.

The bench's scenarios cover the rest. They show which base address each jumper value selects, and that the upper address bits are ignored. They show that both reads and writes at offsets 4 and 5 capture data, and how the two capture modes lock each other out. They also show that the unused offsets leave every register alone. All of these need a sequence of accesses followed by a read-back through the host bus.

// File: rtl/ioport_pkg.sv
package ioport_pkg;
   localparam int SEL_N = 8;
   localparam int OFF_W = 3;
   localparam int CAP_OFF = 4;

   typedef logic [SEL_N-1:0] sel_t;

   function automatic logic [15:0] base_of(input logic [15:0] root,
                                           input logic [15:0] step,
                                           input logic [1:0]  pick);
      return root + step * {14'd0, pick};
   endfunction
endpackage

// File: rtl/ioport_decode.sv
module ioport_decode
   import ioport_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DEC_W     = 11,
   parameter int BASE_ROOT = 'h300,
   parameter int BASE_STEP = 'h10
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              aen,
   input  logic [1:0]        base_sel,
   output sel_t              sel
);
   localparam logic [15:0] ROOT16 = BASE_ROOT[15:0];
   localparam logic [15:0] STEP16 = BASE_STEP[15:0];

   logic [15:0] base_full;
   logic        hit;

   always_comb begin
      base_full = base_of(ROOT16, STEP16, base_sel);
      hit       = !aen && (addr[DEC_W-1:OFF_W] == base_full[DEC_W-1:OFF_W]);
      sel       = '0;
      if (hit) sel[addr[OFF_W-1:0]] = 1'b1;
   end

   logic unused_base;
   assign unused_base = ^{base_full[15:DEC_W], base_full[OFF_W-1:0]};

   generate
      if (ADDR_W > DEC_W) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^addr[ADDR_W-1:DEC_W];
      end
   endgenerate
endmodule

// File: rtl/ioport_rise.sv
module ioport_rise #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_n,
   output logic [W-1:0] rise,
   output logic [W-1:0] prev_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_n <= '1;
      else        prev_n <= lvl_n;
   end

   assign rise = ~prev_n & lvl_n;
endmodule

// File: rtl/ioport_chan.sv
module ioport_chan #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_load,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic              host_cap,
   input  logic              ext_mode,
   input  logic              ext_rise,
   input  logic [DATA_W-1:0] ext_byte,
   output logic [DATA_W-1:0] out_q,
   output logic [DATA_W-1:0] in_q
);
   logic cap_go;
   assign cap_go = ext_mode ? ext_rise : host_cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         in_q  <= '0;
      end else begin
         if (wr_load) out_q <= wr_byte;
         if (cap_go)  in_q  <= ext_byte;
      end
   end
endmodule

// File: rtl/ioport_regs.sv
module ioport_regs
   import ioport_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DEC_W     = 11,
   parameter int DATA_W    = 8,
   parameter int NCH       = 2,
   parameter int BASE_ROOT = 'h300,
   parameter int BASE_STEP = 'h10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     io_addr,
   input  logic                  io_aen,
   input  logic                  io_rd_n,
   input  logic                  io_wr_n,
   input  logic [DATA_W-1:0]     io_wdata,
   output logic [DATA_W-1:0]     io_rdata,
   output logic                  io_rdata_oe,
   input  logic [1:0]            base_sel,
   input  logic [NCH-1:0]        cap_ext,
   input  logic [NCH-1:0]        ext_stb_n,
   input  logic [NCH*DATA_W-1:0] ext_data,
   output logic [NCH*DATA_W-1:0] out_data
);
   localparam int   EW        = NCH + 2;
   localparam sel_t USED_MASK = sel_t'(((1 << NCH) - 1) | (((1 << NCH) - 1) << CAP_OFF));

   initial begin
      if (NCH < 1 || NCH > CAP_OFF)
         $error("ioport_regs: NCH must be 1..%0d", CAP_OFF);
      if (DEC_W <= OFF_W || DEC_W > ADDR_W || DEC_W > 16)
         $error("ioport_regs: DEC_W out of range");
      if ((BASE_ROOT % SEL_N) != 0 || (BASE_STEP % SEL_N) != 0)
         $error("ioport_regs: base and step must be multiples of %0d", SEL_N);
      if (DATA_W < 1)
         $error("ioport_regs: DATA_W must be positive");
   end

   sel_t sel_now, sel_hold;
   logic [DATA_W-1:0] wbyte_hold;
   logic any_low;

   ioport_decode #(
      .ADDR_W(ADDR_W), .DEC_W(DEC_W),
      .BASE_ROOT(BASE_ROOT), .BASE_STEP(BASE_STEP)
   ) u_dec (
      .addr(io_addr), .aen(io_aen), .base_sel(base_sel), .sel(sel_now)
   );

   logic [EW-1:0] rise, prev_n;
   ioport_rise #(.W(EW)) u_rise (
      .clk(clk), .rst_n(rst_n),
      .lvl_n({ext_stb_n, io_wr_n, io_rd_n}),
      .rise(rise), .prev_n(prev_n)
   );

   logic rd_rise, wr_rise;
   assign rd_rise = rise[0];
   assign wr_rise = rise[1];

   assign any_low = !io_rd_n || !io_wr_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_hold   <= '0;
         wbyte_hold <= '0;
      end else begin
         sel_hold <= any_low ? sel_now : '0;
         if (!io_wr_n) wbyte_hold <= io_wdata;
      end
   end

   logic [DATA_W-1:0] in_regs [NCH];

   genvar ch;
   generate
      for (ch = 0; ch < NCH; ch++) begin : g_ch
         ioport_chan #(.DATA_W(DATA_W)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .wr_load(wr_rise && sel_hold[ch]),
            .wr_byte(wbyte_hold),
            .host_cap((wr_rise || rd_rise) && sel_hold[CAP_OFF+ch]),
            .ext_mode(cap_ext[ch]),
            .ext_rise(rise[2+ch]),
            .ext_byte(ext_data[ch*DATA_W +: DATA_W]),
            .out_q(out_data[ch*DATA_W +: DATA_W]),
            .in_q(in_regs[ch])
         );
      end
   endgenerate

   always_comb begin
      io_rdata_oe = 1'b0;
      io_rdata    = '0;
      if (!io_rd_n) begin
         for (int i = 0; i < NCH; i++) begin
            if (sel_now[i]) begin
               io_rdata_oe = 1'b1;
               io_rdata    = io_rdata | in_regs[i];
            end
         end
      end
   end

   logic unused_sel;
   assign unused_sel = ^{(sel_hold & ~USED_MASK), (sel_now & ~USED_MASK), prev_n};
endmodule

// File: rtl/ioport_regs_chk.sv
module ioport_regs_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int NCH    = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [ADDR_W-1:0]     io_addr,
   input logic                  io_aen,
   input logic                  io_rd_n,
   input logic                  io_wr_n,
   input logic [DATA_W-1:0]     io_rdata,
   input logic                  io_rdata_oe,
   input logic [NCH*DATA_W-1:0] out_data
);
   // R1
   reset_clear_chk: assert property (@(posedge clk) !rst_n |-> out_data == '0);

   // R3
   dma_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_aen |-> !io_rdata_oe);

   // R5
   drive_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_rdata_oe |-> (!io_rd_n && !io_aen));

   // R8
   drive_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_rdata_oe |-> (io_addr[2:1] == 2'b00));

   // R9
   quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rdata_oe |-> io_rdata == '0);

   // R10
   out_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(out_data) |-> ($past(io_wr_n) && !$past(io_wr_n, 2)));
endmodule

bind ioport_regs ioport_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH)) u_chk (
   .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_aen(io_aen),
   .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .io_rdata(io_rdata),
   .io_rdata_oe(io_rdata_oe), .out_data(out_data)
);

// File: tb/sim_ioport_regs.sv
`timescale 1ns/1ps
module sim_ioport_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_aen = 1'b0;
   logic        io_rd_n = 1'b1;
   logic        io_wr_n = 1'b1;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        io_rdata_oe;
   logic [1:0]  base_sel = 2'd0;
   logic [1:0]  cap_ext = 2'b00;
   logic [1:0]  ext_stb_n = 2'b11;
   logic [15:0] ext_data = '0;
   logic [15:0] out_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ioport_regs u0 (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_aen(io_aen),
      .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .io_wdata(io_wdata),
      .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe), .base_sel(base_sel),
      .cap_ext(cap_ext), .ext_stb_n(ext_stb_n), .ext_data(ext_data),
      .out_data(out_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] base_addr(input logic [1:0] s);
      return 16'h300 + 16'h10 * {14'd0, s};
   endfunction

   // one host access; returns drive enable and data seen while the strobe was low
   task automatic access(input logic [15:0] a, input bit wr, input logic [7:0] d,
                         output logic oe, output logic [7:0] rd);
      @(negedge clk);
      io_addr  = a;
      io_wdata = d;
      if (wr) io_wr_n = 1'b0; else io_rd_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      oe = io_rdata_oe;
      rd = io_rdata;
      io_wr_n = 1'b1;
      io_rd_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic host_read(input logic [15:0] a, output logic oe, output logic [7:0] rd);
      access(a, 1'b0, 8'h00, oe, rd);
   endtask

   task automatic host_write(input logic [15:0] a, input logic [7:0] d);
      logic o;
      logic [7:0] r;
      access(a, 1'b1, d, o, r);
   endtask

   task automatic ext_pulse(input int ch);
      @(negedge clk);
      ext_stb_n[ch] = 1'b0;
      @(negedge clk);
      @(negedge clk);
      ext_stb_n[ch] = 1'b1;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic oe;
      logic [7:0] rd;
      check("R1 out_data in reset", out_data, 16'h0000);
      check("R9 idle bus in reset", {io_rdata_oe, io_rdata}, 9'h000);
      @(negedge clk);
      rst_n = 1'b1;
      host_read(base_addr(0), oe, rd);
      check("R1 input reg 1 after reset", {oe, rd}, {1'b1, 8'h00});
      host_read(base_addr(0) + 1, oe, rd);
      check("R1 input reg 2 after reset", {oe, rd}, {1'b1, 8'h00});
   endtask

   task automatic t_write();
      base_sel = 2'd0;
      host_write(16'h300, 8'hA5);
      check("R4 write offset 0", out_data, 16'h00A5);
      host_write(16'h301, 8'h3C);
      check("R4 write offset 1", out_data, 16'h3CA5);
   endtask

   task automatic t_base();
      base_sel = 2'd2;
      host_write(16'h300, 8'h11);
      check("R2 old base ignored", out_data, 16'h3CA5);
      host_write(16'h320, 8'h22);
      check("R2 base 0x320", out_data, 16'h3C22);
      host_write(16'hF321, 8'h44);
      check("R2 upper bits ignored", out_data, 16'h4422);
      host_write(16'h328, 8'h55);
      check("R2 bit 3 mismatch ignored", out_data, 16'h4422);
      base_sel = 2'd3;
      host_write(16'h330, 8'h66);
      check("R2 base 0x330", out_data, 16'h4466);
      base_sel = 2'd1;
      host_write(16'h311, 8'h77);
      check("R2 base 0x310", out_data, 16'h7766);
      base_sel = 2'd0;
   endtask

   task automatic t_aen();
      logic oe;
      logic [7:0] rd;
      io_aen = 1'b1;
      host_write(16'h300, 8'h99);
      check("R3 write blocked by aen", out_data, 16'h7766);
      ext_data = 16'hBBAA;
      host_write(16'h304, 8'h00);
      host_read(16'h300, oe, rd);
      check("R3 no drive under aen", {oe, rd}, 9'h000);
      io_aen = 1'b0;
      host_read(16'h300, oe, rd);
      check("R3 capture blocked by aen", {oe, rd}, {1'b1, 8'h00});
   endtask

   task automatic t_internal();
      logic oe;
      logic [7:0] rd;
      cap_ext = 2'b00;
      ext_data = 16'h775A;
      host_write(16'h304, 8'hFF);
      host_read(16'h300, oe, rd);
      check("R6 write at offset 4 captures ch0", {oe, rd}, {1'b1, 8'h5A});
      check("R6 capture leaves output regs", out_data, 16'h7766);
      host_read(16'h305, oe, rd);
      check("R6 read at offset 5 does not drive", {oe, rd}, 9'h000);
      host_read(16'h301, oe, rd);
      check("R5 R6 read at offset 5 captured ch1", {oe, rd}, {1'b1, 8'h77});
      host_read(16'h300, oe, rd);
      check("R5 read offset 0 unchanged", {oe, rd}, {1'b1, 8'h5A});
   endtask

   task automatic t_external();
      logic oe;
      logic [7:0] rd;
      cap_ext = 2'b01;
      ext_data = 16'h2211;
      ext_pulse(0);
      host_read(16'h300, oe, rd);
      check("R7 external strobe loads ch0", {oe, rd}, {1'b1, 8'h11});
      ext_data = 16'h2233;
      host_write(16'h304, 8'h00);
      host_read(16'h300, oe, rd);
      check("R7 host capture ignored in external mode", {oe, rd}, {1'b1, 8'h11});
      ext_pulse(1);
      host_read(16'h301, oe, rd);
      check("R7 strobe ignored in internal mode", {oe, rd}, {1'b1, 8'h77});
      cap_ext = 2'b00;
      ext_pulse(0);
      host_read(16'h300, oe, rd);
      check("R7 ch0 strobe ignored after return to internal", {oe, rd}, {1'b1, 8'h11});
   endtask

   task automatic t_unused();
      logic oe;
      logic [7:0] rd;
      foreach (ext_data[i]) ;
      for (int k = 0; k < 4; k++) begin
         logic [2:0] off;
         off = (k < 2) ? 3'(2 + k) : 3'(4 + k);
         host_write(16'h300 + {13'd0, off}, 8'hE0 + 8'(k));
         check("R8 write unused offset", out_data, 16'h7766);
         host_read(16'h300 + {13'd0, off}, oe, rd);
         check("R8 R9 read unused offset", {oe, rd}, 9'h000);
      end
      host_read(16'h300, oe, rd);
      host_read(16'h301, oe, rd);
      check("R8 input reg 2 kept", {oe, rd}, {1'b1, 8'h77});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_write();
      t_base();
      t_aen();
      t_internal();
      t_external();
      t_unused();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule